// File: doc/BRIEF.md
# Output Start-Up Mute and Ramp Sequencer

This block sequences the start-up and shut-down of a stereo audio output stage. It runs on the master clock. It counts rising edges of the left/right frame clock and uses them to time two phases. First the outputs are held clamped to ground for a fixed number of frames. Then a digital level code climbs one step per frame from zero up to a terminal count that stands for the quiescent mid-supply voltage. Audio is enabled only once that count is reached.

An external mute-control output stays high whenever the output is not in normal playback. It also rises at once for a user mute request and for an invalid master-to-frame clock ratio. A ratio fault during playback drops audio but keeps the level code. When the ratio comes back, playback resumes without a second ramp. While reset is low, every state machine is held at its default state, and a discharge request replaces the output drive.

The clamp length and the ramp terminal count are parameters, so a short sequence can be run in simulation. All pins are plain control and status levels. No data stream passes through this block.

Top module: `out_ramp_seq`

## Requirements
- R1: While rst_n is low (asynchronous), discharge_req=1, clamp_gnd=1, ramp_level=0, audio_en=0 and mute_ctl=1.
- R2: On the first master-clock edge after reset release, discharge_req falls to 0 while clamp_gnd stays 1.
- R3: clamp_gnd stays 1 with ramp_level=0 for exactly CLAMP_FRAMES counted frame-clock rising edges, then falls to 0.
- R4: In the ramp phase, ramp_level rises by exactly one per counted frame-clock rising edge, starting from 0.
- R5: ramp_level saturates at RAMP_TOP. audio_en becomes 1 on the same edge that ramp_level reaches RAMP_TOP. Further frames leave the level unchanged.
- R6: mute_ctl is 1 whenever audio_en is 0.
- R7: mute_req=1 drives mute_ctl to 1 in the same cycle, with no change to audio_en or ramp_level.
- R8: ratio_ok=0 drives mute_ctl to 1 in the same cycle. During playback, audio_en drops on the next clock edge and ramp_level is held. When ratio_ok returns to 1, audio_en returns on the next edge with ramp_level still at RAMP_TOP.
- R9: During the clamp and ramp phases, frame edges that arrive while ratio_ok=0 are not counted.
- R10: A frame-clock rising edge passes through a two-flop synchroniser and takes effect on the third master-clock rising edge after it. Each rising edge is counted once only, however long frame_clk stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset / power-down |
| frame_clk | input | 1 | Left/right frame clock, asynchronous to clk |
| ratio_ok | input | 1 | Master-to-frame clock ratio is valid |
| mute_req | input | 1 | User mute request |
| clamp_gnd | output | 1 | Hold the outputs at ground |
| discharge_req | output | 1 | Request the soft discharge path in place of the output drive |
| ramp_level | output | LVL_W | Digital level code, 0 up to RAMP_TOP |
| audio_en | output | 1 | Audio output enabled |
| mute_ctl | output | 1 | External mute control, high means muted |

## Verification
A frame-clock rise takes effect on the third master-clock edge after it, so each frame pulse the bench drives lasts eight clocks before the next sample. Every count-based result (clamp end, ramp step, audio enable at the top) is therefore settled when it is read. The discharge release and the playback drop or resume after a ratio change are due one clock edge after the stimulus. The bench samples them just after the following falling edge. Mute from mute_req or ratio_ok is combinational, and the reset outputs are asynchronous. Both are sampled one time unit after the input changes, with no clock edge in between.

// File: rtl/oseq_pkg.sv
package oseq_pkg;
  typedef enum logic [2:0] {
    SQ_OFF   = 3'd0,
    SQ_CLAMP = 3'd1,
    SQ_RAMP  = 3'd2,
    SQ_PLAY  = 3'd3,
    SQ_HOLD  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/oseq_frame_edge.sv
// Synchronises the frame clock into the master clock domain and emits a
// one-cycle pulse per rising edge.
module oseq_frame_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_clk,
  output logic frame_edge
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-2:0], frame_clk};
  end

  assign frame_edge = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  // R10: a rising edge yields a single-cycle pulse only
  a_r10_edge_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    frame_edge |=> !frame_edge);
endmodule

// File: rtl/oseq_ramp.sv
// Level code generator: cleared during clamp, one step per counted frame.
module oseq_ramp #(
  parameter int RAMP_TOP = 10000,
  parameter int LVL_W    = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [LVL_W-1:0] level,
  output logic             last_step
);
  localparam logic [LVL_W-1:0] TOP_C  = LVL_W'(RAMP_TOP);
  localparam logic [LVL_W-1:0] LAST_C = LVL_W'(RAMP_TOP - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      level <= '0;
    else if (clear)                  level <= '0;
    else if (step && level != TOP_C) level <= level + 1'b1;
  end

  assign last_step = (level == LAST_C);

  // R4: the level never jumps by more than one step or goes down except on clear
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (level == $past(level) || level == $past(level) + 1'b1));
  // R5: saturation bound
  a_r5_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
    level <= TOP_C);
endmodule

// File: rtl/oseq_fsm.sv
// Phase sequencer with clamp frame counter.
module oseq_fsm
  import oseq_pkg::*;
#(
  parameter int CLAMP_FRAMES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_edge,
  input  logic       ratio_ok,
  input  logic       ramp_last,
  output seq_state_e state,
  output logic       ramp_step,
  output logic       ramp_clear
);
  localparam int CNT_W = $clog2(CLAMP_FRAMES + 1);
  localparam logic [CNT_W-1:0] CLAMP_LAST = CNT_W'(CLAMP_FRAMES - 1);

  seq_state_e       nxt;
  logic [CNT_W-1:0] clamp_cnt;
  logic             tick;

  assign tick       = frame_edge & ratio_ok;
  assign ramp_step  = (state == SQ_RAMP) & tick;
  assign ramp_clear = (state == SQ_OFF) | (state == SQ_CLAMP);

  always_comb begin
    nxt = state;
    unique case (state)
      SQ_OFF:   nxt = SQ_CLAMP;
      SQ_CLAMP: if (tick && clamp_cnt == CLAMP_LAST) nxt = SQ_RAMP;
      SQ_RAMP:  if (ramp_step && ramp_last) nxt = SQ_PLAY;
      SQ_PLAY:  if (!ratio_ok) nxt = SQ_HOLD;
      SQ_HOLD:  if (ratio_ok) nxt = SQ_PLAY;
      default:  nxt = SQ_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_OFF;
    else        state <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 clamp_cnt <= '0;
    else if (state != SQ_CLAMP) clamp_cnt <= '0;
    else if (tick)              clamp_cnt <= clamp_cnt + 1'b1;
  end

  // R9: with the ratio invalid, the clamp count holds
  a_r9_clamp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_CLAMP && !ratio_ok) |=> $stable(clamp_cnt));
  // R2: the power-down state lasts no longer than one edge after release
  a_r2_off_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    state == SQ_OFF |=> state == SQ_CLAMP);
endmodule

// File: rtl/out_ramp_seq.sv
module out_ramp_seq
  import oseq_pkg::*;
#(
  parameter int CLAMP_FRAMES = 1000,
  parameter int RAMP_TOP     = 10000,
  parameter int LVL_W        = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clk,
  input  logic             ratio_ok,
  input  logic             mute_req,
  output logic             clamp_gnd,
  output logic             discharge_req,
  output logic [LVL_W-1:0] ramp_level,
  output logic             audio_en,
  output logic             mute_ctl
);
  localparam logic [LVL_W-1:0] TOP_C = LVL_W'(RAMP_TOP);

  logic       frame_edge;
  logic       ramp_step;
  logic       ramp_clear;
  logic       ramp_last;
  seq_state_e state;

  oseq_frame_edge #(.SYNC_STAGES(2)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_clk  (frame_clk),
    .frame_edge (frame_edge)
  );

  oseq_fsm #(.CLAMP_FRAMES(CLAMP_FRAMES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_edge (frame_edge),
    .ratio_ok   (ratio_ok),
    .ramp_last  (ramp_last),
    .state      (state),
    .ramp_step  (ramp_step),
    .ramp_clear (ramp_clear)
  );

  oseq_ramp #(.RAMP_TOP(RAMP_TOP), .LVL_W(LVL_W)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ramp_clear),
    .step      (ramp_step),
    .level     (ramp_level),
    .last_step (ramp_last)
  );

  assign clamp_gnd     = (state == SQ_OFF) | (state == SQ_CLAMP);
  assign discharge_req = (state == SQ_OFF);
  assign audio_en      = (state == SQ_PLAY);
  assign mute_ctl      = ~audio_en | mute_req | ~ratio_ok;

  // R5: audio is only enabled at the full level
  a_r5_audio_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    audio_en |-> ramp_level == TOP_C);
  // R3: while clamped the level code is zero
  a_r3_clamp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_gnd |-> ramp_level == '0);
  // R8: a ratio fault during play holds the level
  a_r8_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    (audio_en && !ratio_ok) |=> ramp_level == TOP_C);
endmodule

// File: tb/out_ramp_seq_tb_top.sv
`timescale 1ns/1ps
module out_ramp_seq_tb_top;
  localparam int CLAMP = 5;
  localparam int TOP   = 12;
  localparam int LW    = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_clk = 1'b0;
  logic ratio_ok = 1'b1;
  logic mute_req = 1'b0;
  logic clamp_gnd, discharge_req, audio_en, mute_ctl;
  logic [LW-1:0] ramp_level;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  out_ramp_seq #(.CLAMP_FRAMES(CLAMP), .RAMP_TOP(TOP), .LVL_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .ratio_ok(ratio_ok),
    .mute_req(mute_req), .clamp_gnd(clamp_gnd), .discharge_req(discharge_req),
    .ramp_level(ramp_level), .audio_en(audio_en), .mute_ctl(mute_ctl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame_clk = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk) frame_clk = 1'b0;
      repeat (4) @(posedge clk);
    end
    @(negedge clk); #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; #1;
    chk("R1 discharge", discharge_req, 1);
    chk("R1 clamp", clamp_gnd, 1);
    chk("R1 level", ramp_level, 0);
    chk("R1 audio", audio_en, 0);
    chk("R1 mute", mute_ctl, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R2 discharge released", discharge_req, 0);
    chk("R2 clamp kept", clamp_gnd, 1);
  endtask

  task automatic t_clamp;
    frames(CLAMP - 1);
    chk("R3 clamp before last", clamp_gnd, 1);
    chk("R6 mute in clamp", mute_ctl, 1);
    frames(1);
    chk("R3 clamp released", clamp_gnd, 0);
    chk("R3 level at ramp start", ramp_level, 0);
  endtask

  task automatic t_ramp_fault;
    frames(3);
    chk("R4 level after 3", ramp_level, 3);
    @(negedge clk) ratio_ok = 1'b0; #1;
    chk("R8 mute on fault in ramp", mute_ctl, 1);
    frames(2);
    chk("R9 frames ignored", ramp_level, 3);
    @(negedge clk) ratio_ok = 1'b1;
    frames(1);
    chk("R4 count resumes", ramp_level, 4);
  endtask

  task automatic t_top;
    frames(TOP - 5);
    chk("R5 level one short", ramp_level, TOP - 1);
    chk("R6 not yet audio", audio_en, 0);
    chk("R6 muted before top", mute_ctl, 1);
    frames(1);
    chk("R5 level top", ramp_level, TOP);
    chk("R5 audio on", audio_en, 1);
    chk("R6 unmuted", mute_ctl, 0);
    frames(2);
    chk("R5 saturated", ramp_level, TOP);
  endtask

  task automatic t_mute_req;
    @(negedge clk) mute_req = 1'b1; #1;
    chk("R7 mute asserts", mute_ctl, 1);
    @(negedge clk); #1;
    chk("R7 audio kept", audio_en, 1);
    chk("R7 level kept", ramp_level, TOP);
    mute_req = 1'b0; #1;
    chk("R7 mute clears", mute_ctl, 0);
  endtask

  task automatic t_ratio_play;
    @(negedge clk) ratio_ok = 1'b0; #1;
    chk("R8 mute at once", mute_ctl, 1);
    chk("R8 audio still before edge", audio_en, 1);
    @(negedge clk); #1;
    chk("R8 audio dropped", audio_en, 0);
    frames(2);
    chk("R8 level held", ramp_level, TOP);
    ratio_ok = 1'b1;
    @(negedge clk); #1;
    chk("R8 audio resumed", audio_en, 1);
    chk("R8 no new ramp", ramp_level, TOP);
    chk("R8 unmuted", mute_ctl, 0);
  endtask

  task automatic t_edge_latency;
    // reset again, clamp with one short frame, check latency
    rst_n = 1'b0; #1;
    chk("R1 level cleared mid-play", ramp_level, 0);
    chk("R1 discharge mid-play", discharge_req, 1);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    frames(CLAMP - 1);
    @(negedge clk) frame_clk = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R10 not yet counted", clamp_gnd, 1);
    @(posedge clk); #1;
    chk("R10 counted on third edge", clamp_gnd, 0);
    repeat (20) @(posedge clk);
    @(negedge clk) frame_clk = 1'b0; #1;
    chk("R10 long high counted once", ramp_level, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_clamp();
    t_ramp_fault();
    t_top();
    t_mute_req();
    t_ratio_play();
    t_edge_latency();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule